// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block plans the bank accesses for one group load of 32 lanes against a 32-bank scratchpad. It takes a byte address and an active flag for each lane and breaks the load into rounds that have no conflicts. In a round each bank serves at most one distinct word, and every pending lane that asks for that word is served with it. Lanes that share a word are broadcast together, so only distinct words in the same bank cost extra rounds.

The block issues one round per cycle. Each round gives a per-bank enable, the word index for each bank and the set of lanes served. After the last round the block raises a one-cycle completion pulse that carries the number of rounds used. A mode input picks how words map to banks. In the narrow mode, 4-byte words are interleaved across the banks. In the wide mode, 8-byte words are interleaved. The storage arrays and the data return path are outside this block.

Top module: `bank_conflict_serializer`

## Requirements
- R1: After reset, req_ready is 1, and rnd_valid and done are 0.
- R2: With wide_mode=0, a lane's word index is addr>>2 and its bank is word index mod 32. rnd_word for bank b holds the word index being served from bank b, and bit b of rnd_bank_en is set in that round.
- R3: With wide_mode=1, the word index is addr>>3 and the bank is word index mod 32. The mode is sampled when the request is accepted.
- R4: All pending lanes whose word index is equal are served in the same round.
- R5: Lanes with different word indices in the same bank are served in separate rounds. Within a bank, the next word served is the word of the lowest-numbered pending lane.
- R6: Every lane with its bit set in req_mask appears in rnd_lanes in exactly one round. A lane whose mask bit is clear never appears, whatever its address.
- R7: The number of rounds equals the largest count of distinct word indices that active lanes request from any single bank. done pulses in the cycle after the last round, and done_rounds then holds that count.
- R8: A request with an all-zero mask produces no round. done pulses in the cycle after acceptance, with done_rounds=0.
- R9: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from acceptance until done, and req_valid is ignored during that time.
- R10: Rounds appear in consecutive cycles, starting in the cycle after acceptance. rnd_valid and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to accept a request |
| req_mask | input | 32 | Active lanes |
| req_addr | input | 1024 | Byte address per lane, lane l at bits [32l+31:32l] |
| wide_mode | input | 1 | 1 selects 8-byte interleave, 0 selects 4-byte interleave |
| rnd_valid | output | 1 | A round is presented this cycle |
| rnd_bank_en | output | 32 | Banks accessed in this round |
| rnd_word | output | 1024 | Word index per bank, bank b at bits [32b+31:32b] |
| rnd_lanes | output | 32 | Lanes served in this round |
| done | output | 1 | One-cycle completion pulse |
| done_rounds | output | 6 | Rounds used by the finished request |

## Verification
The assertions take for granted that the request fields are only relevant on the accepting edge, and that nothing outside the block forces a new request into a busy cycle except through req_valid, which the block must ignore. The stimulus drives each request for exactly one cycle while req_ready is high. It raises req_valid once during a busy window only to show that the request is dropped. Between requests it holds every input stable on the falling clock edge.

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [LANES-1:0]     req_mask,
  input  logic [LANES*AW-1:0]  req_addr,
  input  logic                 wide_mode,
  output logic                 rnd_valid,
  output logic [BANKS-1:0]     rnd_bank_en,
  output logic [BANKS*AW-1:0]  rnd_word,
  output logic [LANES-1:0]     rnd_lanes,
  output logic                 done,
  output logic [$clog2(LANES+1)-1:0] done_rounds
);
  localparam int BB = $clog2(BANKS);
  localparam int CW = $clog2(LANES+1);

  logic                busy, wide_q;
  logic [LANES-1:0]    pend;
  logic [LANES*AW-1:0] addr_q;
  logic [CW-1:0]       cnt;

  logic [AW-1:0] word [LANES];
  logic [BB-1:0] bnk  [LANES];
  logic [AW-1:0] selw [BANKS];
  logic [BANKS-1:0] hit;
  logic [LANES-1:0] served;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      word[l] = wide_q ? (addr_q[l*AW +: AW] >> 3) : (addr_q[l*AW +: AW] >> 2);
      bnk[l]  = word[l][BB-1:0];
    end
    for (int b = 0; b < BANKS; b++) begin
      hit[b]  = 1'b0;
      selw[b] = '0;
      for (int l = LANES-1; l >= 0; l--) begin
        if (pend[l] && bnk[l] == BB'(b)) begin
          hit[b]  = 1'b1;
          selw[b] = word[l];
        end
      end
    end
    for (int l = 0; l < LANES; l++)
      served[l] = pend[l] && (word[l] == selw[bnk[l]]);
  end

  assign req_ready   = !busy;
  assign rnd_valid   = busy && (|pend);
  assign done        = busy && !(|pend);
  assign rnd_lanes   = served;
  assign rnd_bank_en = hit;
  assign done_rounds = cnt;

  for (genvar b = 0; b < BANKS; b++) begin : g_word
    assign rnd_word[b*AW +: AW] = selw[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wide_q <= 1'b0;
      pend   <= '0;
      addr_q <= '0;
      cnt    <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy   <= 1'b1;
        wide_q <= wide_mode;
        pend   <= req_mask;
        addr_q <= req_addr;
        cnt    <= '0;
      end
    end else if (|pend) begin
      pend <= pend & ~served;
      cnt  <= cnt + 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_conflict_serializer_chk.sv
module bank_conflict_serializer_chk #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [LANES-1:0]     req_mask,
  input logic [LANES*AW-1:0]  req_addr,
  input logic                 wide_mode,
  input logic                 rnd_valid,
  input logic [BANKS-1:0]     rnd_bank_en,
  input logic [BANKS*AW-1:0]  rnd_word,
  input logic [LANES-1:0]     rnd_lanes,
  input logic                 done,
  input logic [$clog2(LANES+1)-1:0] done_rounds
);
  localparam int CW = $clog2(LANES+1);
  logic [LANES-1:0] mask_c, served_c;
  logic [CW-1:0]    cnt_c;
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_c <= '0; served_c <= '0; cnt_c <= '0;
    end else if (accept) begin
      mask_c <= req_mask; served_c <= '0; cnt_c <= '0;
    end else if (rnd_valid) begin
      served_c <= served_c | rnd_lanes; cnt_c <= cnt_c + 1'b1;
    end
  end

  AST_ROUND_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) rnd_valid |-> (rnd_lanes != '0 && rnd_bank_en != '0)); // R6
  AST_NO_RESERVE: assert property (@(posedge clk) disable iff (!rst_n) rnd_valid |-> ((rnd_lanes & served_c) == '0)); // R6
  AST_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) rnd_valid |-> ((rnd_lanes & ~mask_c) == '0)); // R6
  AST_FULL_COVER: assert property (@(posedge clk) disable iff (!rst_n) done |-> (served_c == mask_c)); // R6
  AST_ROUND_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done |-> (done_rounds == cnt_c)); // R7
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n) (accept && req_mask == '0) |=> (done && done_rounds == '0)); // R8
  AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rst_n) rnd_valid |-> !req_ready); // R9
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n) done |=> req_ready); // R9
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n) (accept && req_mask != '0) |=> rnd_valid); // R10
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(rnd_valid && done)); // R10
endmodule

bind bank_conflict_serializer bank_conflict_serializer_chk #(.LANES(LANES), .BANKS(BANKS), .AW(AW)) u_chk (.*);

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, wide_mode = 0;
  logic [31:0] req_mask = 0;
  logic [1023:0] req_addr = 0;
  logic req_ready, rnd_valid, done;
  logic [31:0] rnd_bank_en, rnd_lanes;
  logic [1023:0] rnd_word;
  logic [5:0] done_rounds;
  int checks = 0, fails = 0;
  logic [31:0] a [32];

  always #2 clk = ~clk;

  bank_conflict_serializer uut (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input logic [31:0] ad, input bit w);
    return w ? (ad >> 3) : (ad >> 2);
  endfunction

  function automatic int exp_rounds(input logic [31:0] m, input bit w);
    int best = 0;
    for (int b = 0; b < 32; b++) begin
      int n = 0;
      for (int i = 0; i < 32; i++) begin
        bit fresh = 1;
        if (!m[i] || wd(a[i], w) % 32 != b) continue;
        for (int j = 0; j < i; j++)
          if (m[j] && wd(a[j], w) == wd(a[i], w)) fresh = 0;
        if (fresh) n++;
      end
      if (n > best) best = n;
    end
    return best;
  endfunction

  // Runs one request; checks mapping, broadcast, coverage, count and timing.
  task automatic run(input logic [31:0] m, input bit w, input string tag, input bit poke);
    logic [31:0] seen = 0;
    int cyc = 0, bad = 0, er;
    bit fin = 0;
    er = exp_rounds(m, w);
    @(negedge clk);
    for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
    req_mask = m; wide_mode = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0; req_mask = 0; wide_mode = ~w;
    for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = 32'hFFFF_FFFF;
    while (!fin && cyc < 80) begin
      if (done) fin = 1;
      else if (!rnd_valid) bad++;
      else begin
        for (int i = 0; i < 32; i++) if (rnd_lanes[i]) begin
          logic [31:0] wv = wd(a[i], w);
          if (!m[i] || seen[i] || !rnd_bank_en[wv % 32] || rnd_word[(wv % 32)*32 +: 32] != wv) bad++;
        end
        for (int i = 0; i < 32; i++) if (m[i] && !seen[i] && !rnd_lanes[i]) begin
          logic [31:0] wv = wd(a[i], w);
          if (rnd_bank_en[wv % 32] && rnd_word[(wv % 32)*32 +: 32] == wv) bad++;
        end
        seen |= rnd_lanes;
        cyc++;
      end
      if (poke && cyc == 1 && !fin) begin
        chk(req_ready == 0, "R9", {tag, " ready while busy"}, req_ready, 0);
        for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = 32'(i) * 128;
        req_mask = '1; req_valid = 1;
      end
      @(negedge clk);
      req_valid = 0;
    end
    chk(fin, "R10", {tag, " done seen"}, fin, 1);
    chk(bad == 0, "R2/R4", {tag, " round content"}, bad, 0);
    chk(seen == m, "R6", {tag, " lanes covered"}, seen, m);
    chk(cyc == er, "R7", {tag, " round count"}, cyc, er);
    chk(done_rounds == 6'(er), "R7", {tag, " done_rounds"}, done_rounds, er);
    chk(req_ready == 1, "R9", {tag, " ready after done"}, req_ready, 1);
  endtask

  task automatic t_reset();
    chk(req_ready && !rnd_valid && !done, "R1", "reset state", {req_ready, rnd_valid, done}, 3'b100);
  endtask

  task automatic t_order();
    for (int i = 0; i < 32; i++) a[i] = 0;
    a[0] = 128; a[1] = 0; a[2] = 128;
    @(negedge clk);
    for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
    req_mask = 32'h7; wide_mode = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rnd_valid && rnd_lanes == 32'h5 && rnd_word[31:0] == 32, "R5", "first round lanes 0,2 word 32", rnd_lanes, 5);
    @(negedge clk);
    chk(rnd_valid && rnd_lanes == 32'h2 && rnd_word[31:0] == 0, "R5", "second round lane 1 word 0", rnd_lanes, 2);
    @(negedge clk);
    chk(done && done_rounds == 2, "R7", "order done", done_rounds, 2);
    @(negedge clk);
  endtask

  task automatic t_empty();
    for (int i = 0; i < 32; i++) a[i] = 32'(i) * 128;
    @(negedge clk);
    req_mask = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(done && !rnd_valid && done_rounds == 0, "R8", "empty request", done_rounds, 0);
    @(negedge clk);
    chk(req_ready, "R8", "idle after empty", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    for (int i = 0; i < 32; i++) a[i] = 32'(i) * 4;
    run('1, 0, "R2 linear words", 0);
    for (int i = 0; i < 32; i++) a[i] = 32'(i);
    run('1, 0, "R4 bytes", 0);
    for (int i = 0; i < 32; i++) a[i] = 32'(i) * 2;
    run('1, 0, "R4 halfwords", 0);
    for (int i = 0; i < 32; i++) a[i] = 32'(i) * 8;
    run('1, 0, "R5 stride8 narrow", 0);
    run('1, 1, "R3 stride8 wide", 0);
    for (int i = 0; i < 32; i++) a[i] = 32'h40;
    run('1, 0, "R4 same address", 0);
    for (int i = 0; i < 32; i++) a[i] = 32'(i) * 128;
    run('1, 0, "R5 all bank0", 1);
    run(32'h5555_5555, 0, "R6 even lanes only", 0);
    for (int i = 0; i < 32; i++) a[i] = 32'(i) * 36;
    run(32'hF0F0_0F0F, 1, "R3 wide mixed", 0);
    t_order();
    t_empty();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule